// File: doc/BRIEF.md
# Receive Rate Adaptation Sampler

This block sits on the receive side of a MAC that is fed by a serial gigabit PHY link. Behind the PCS decoder, frames always arrive at the 125 MHz byte rate. When the link runs at 100 or 10 Mbps, each real byte is repeated 10 or 100 times. The sampler picks one copy of each byte out of that stretched stream and produces a single sample strobe per recovered byte. Each sample carries the byte and an error flag. The flag is set when the error input was high on any cycle of that byte's window.

The sampling phase has no global boundary. It is anchored to the cycle in which receive valid rises, and a new frame re-anchors it. The sampler captures each byte at the head of its window, so a first byte that carries one copy fewer than normal does not move the later samples off their bytes. The speed code is taken once per frame, at the rising edge of valid. Carrier sense and collision come from receive valid before any rate adaptation: carrier sense follows valid, and collision is valid AND the local transmit enable. Both are registered once.

The sample stream is valid-only. The strobe `smp_valid` qualifies `smp_data` and `smp_err` for exactly one cycle. The upstream PCS stream cannot be stalled, so there is no ready signal, and the consumer must take every strobed byte in the cycle it appears.

Top module: `rx_rate_sampler`

## Requirements
- R1: With speed code 2'b10 (1000 Mbps), every cycle with `in_dv` high yields one sample. `smp_valid` is high in the next cycle, carrying that cycle's `in_data` and `in_er`.
- R2: With speed code 2'b01 (100 Mbps), byte window k of a frame covers cycles F+10k to F+10k+9, where F is the cycle in which `in_dv` rose. Its sample carries `in_data` of cycle F+10k and appears in cycle F+10k+10.
- R3: With speed code 2'b00 (10 Mbps), the same rule applies with windows of 100 cycles.
- R4: The window phase restarts at every rising edge of `in_dv`, whatever the phase reached in the previous frame, including a previous frame that ended in the middle of a window and was followed by a single idle cycle.
- R5: A first byte repeated only 9 (100 Mbps) or 99 (10 Mbps) times is still recovered, and every later byte of the frame is recovered with unchanged sample timing.
- R6: `smp_err` of a sample is the OR of `in_er` over every cycle of that byte's window, including the window's last cycle. An error in one window does not mark any other sample.
- R7: When `in_dv` falls with a window partly filled, that partial byte is emitted in the cycle after the first cycle with `in_dv` low. While no frame is open, no sample appears.
- R8: `speed_sel` is taken only in the cycle in which `in_dv` rises. A change during a frame has no effect until the next frame.
- R9: `crs` equals `in_dv` of the previous cycle.
- R10: `col` equals (`in_dv` AND `tx_en`) of the previous cycle.
- R11: After reset, `smp_valid`, `crs` and `col` are low.
- R12: The reserved speed code 2'b11 behaves as 1000 Mbps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz receive byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_dv | input | 1 | Decoded receive valid, stretched |
| in_er | input | 1 | Decoded receive error, stretched |
| in_data | input | DW | Decoded receive byte, stretched |
| speed_sel | input | 2 | Link speed code: 10=1000, 01=100, 00=10, 11=as 1000 |
| tx_en | input | 1 | Local transmit enable |
| smp_valid | output | 1 | One-cycle strobe per recovered byte |
| smp_data | output | DW | Recovered byte |
| smp_err | output | 1 | Error seen anywhere in the byte window |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision |

## Verification
The error accumulator and the window-close emission can act in the same cycle. An error placed on the tenth copy of a 100 Mbps byte arrives in exactly the cycle that closes its window and emits the byte. The bench checks that this error marks that byte and not the next one. A second collision of functions comes when a frame ends mid-window and a new frame starts one idle cycle later. The partial-byte flush then lands in the cycle just before the new frame's phase reset, and the bench checks the flushed byte and the second frame's sample timing against its own rising edge.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef enum logic [1:0] {
    SPD_10   = 2'b00,
    SPD_100  = 2'b01,
    SPD_1000 = 2'b10,
    SPD_RSV  = 2'b11
  } spd_e;
endpackage

// File: rtl/rrs_phase.sv
module rrs_phase
  import rrs_pkg::*;
#(
  parameter int unsigned R100 = 10,
  parameter int unsigned R10  = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dv,
  input  logic [1:0] spd,
  output logic       first,
  output logic       last
);
  localparam int unsigned CW = $clog2(R10 + 1);

  function automatic logic [CW-1:0] win_len(input logic [1:0] s);
    case (spd_e'(s))
      SPD_10:  return CW'(R10);
      SPD_100: return CW'(R100);
      default: return CW'(1);
    endcase
  endfunction

  logic          dv_q;
  logic [CW-1:0] n_q, cnt_q, n_now, ph;
  logic          rise;

  always_comb begin
    rise  = dv & ~dv_q;
    n_now = rise ? win_len(spd) : n_q;
    ph    = rise ? '0 : cnt_q;
    first = dv && (ph == '0);
    last  = dv && (ph == n_now - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dv_q  <= 1'b0;
      n_q   <= CW'(1);
      cnt_q <= '0;
    end else begin
      dv_q <= dv;
      if (rise) n_q <= n_now;
      if (dv) cnt_q <= last ? '0 : ph + CW'(1);
      else    cnt_q <= '0;
    end
  end

  // R4: a rising valid starts the count at slot zero
  p_rise_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dv && !dv_q && n_now > CW'(1)) |=> (cnt_q == CW'(1)));

  // R8: the window length does not move inside a frame
  p_speed_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dv && dv_q) |=> $stable(n_q));
endmodule

// File: rtl/rrs_window.sv
module rrs_window #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dv,
  input  logic          er,
  input  logic [DW-1:0] data,
  input  logic          first,
  input  logic          last,
  output logic          vld,
  output logic [DW-1:0] dout,
  output logic          eout
);
  logic [DW-1:0] hold_q, cap;
  logic          acc_q, acc_now, open_q;

  always_comb begin
    cap     = first ? data : hold_q;
    acc_now = (first ? 1'b0 : acc_q) | er;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      acc_q  <= 1'b0;
      open_q <= 1'b0;
      vld    <= 1'b0;
      dout   <= '0;
      eout   <= 1'b0;
    end else begin
      vld <= 1'b0;
      if (dv) begin
        if (last) begin
          vld    <= 1'b1;
          dout   <= cap;
          eout   <= acc_now;
          open_q <= 1'b0;
        end else begin
          hold_q <= cap;
          acc_q  <= acc_now;
          open_q <= 1'b1;
        end
      end else if (open_q) begin
        vld    <= 1'b1;
        dout   <= hold_q;
        eout   <= acc_q;
        open_q <= 1'b0;
      end
    end
  end

  // R7: a partly filled window is emitted once valid drops
  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dv && open_q) |=> vld);

  // R7: no sample without an open frame
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dv && !open_q) |=> !vld);

  // R6: an error inside an unfinished window stays recorded
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dv && er && !last) |=> (open_q && acc_q));
endmodule

// File: rtl/rrs_carrier.sv
module rrs_carrier (
  input  logic clk,
  input  logic rst_n,
  input  logic dv,
  input  logic tx_en,
  output logic crs,
  output logic col
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crs     <= 1'b0;
      col     <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      crs     <= dv;
      col     <= dv & tx_en;
      armed_q <= 1'b1;
    end
  end

  // R9: carrier follows raw valid one cycle later
  p_crs_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (crs == $past(dv)));

  // R10: collision is raw valid together with transmit enable
  p_col_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (col == $past(dv & tx_en)));
endmodule

// File: rtl/rx_rate_sampler.sv
module rx_rate_sampler #(
  parameter int unsigned DW   = 8,
  parameter int unsigned R100 = 10,
  parameter int unsigned R10  = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_dv,
  input  logic          in_er,
  input  logic [DW-1:0] in_data,
  input  logic [1:0]    speed_sel,
  input  logic          tx_en,
  output logic          smp_valid,
  output logic [DW-1:0] smp_data,
  output logic          smp_err,
  output logic          crs,
  output logic          col
);
  logic first, last;

  rrs_phase #(.R100(R100), .R10(R10)) u_phase (
    .clk(clk), .rst_n(rst_n), .dv(in_dv), .spd(speed_sel),
    .first(first), .last(last)
  );

  rrs_window #(.DW(DW)) u_win (
    .clk(clk), .rst_n(rst_n), .dv(in_dv), .er(in_er), .data(in_data),
    .first(first), .last(last),
    .vld(smp_valid), .dout(smp_data), .eout(smp_err)
  );

  rrs_carrier u_car (
    .clk(clk), .rst_n(rst_n), .dv(in_dv), .tx_en(tx_en),
    .crs(crs), .col(col)
  );

  // R1: a one-slot window passes its byte straight through
  p_gig_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (first && last) |=> (smp_valid && smp_data == $past(in_data)
                         && smp_err == $past(in_er)));
endmodule

// File: tb/sim_rx_rate_sampler.sv
`timescale 1ns/1ps
module sim_rx_rate_sampler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_dv = 1'b0, in_er = 1'b0, tx_en = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] speed_sel = 2'b10;
  logic       smp_valid, smp_err, crs, col;
  logic [7:0] smp_data;

  always #10 clk = ~clk;

  rx_rate_sampler u0 (
    .clk(clk), .rst_n(rst_n), .in_dv(in_dv), .in_er(in_er), .in_data(in_data),
    .speed_sel(speed_sel), .tx_en(tx_en), .smp_valid(smp_valid),
    .smp_data(smp_data), .smp_err(smp_err), .crs(crs), .col(col)
  );

  int total = 0, fails = 0, cyc = 0, ev_n = 0;
  int ev_c [512];
  logic [7:0] ev_d [512];
  logic ev_e [512];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    if (smp_valid && ev_n < 512) begin
      ev_c[ev_n] = cyc; ev_d[ev_n] = smp_data; ev_e[ev_n] = smp_err;
      ev_n = ev_n + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int win_of(input logic [1:0] s);
    return (s == 2'b01) ? 10 : (s == 2'b00) ? 100 : 1;
  endfunction

  function automatic logic [7:0] byte_of(input int k, input int seed);
    return 8'((k * 29 + seed) & 255);
  endfunction

  // Drives one frame and checks every sample it should produce.
  task automatic run_frame(input string req, input logic [1:0] spd, input int n,
                           input int first_reps, input int last_reps,
                           input int eb, input int eo, input int gap,
                           input int chg_at, input logic [1:0] chg_spd, input int seed);
    int w, rise, len, fc, base, cnt, expc;
    w = win_of(spd); base = ev_n; fc = 0; len = 0; rise = 0;
    for (int k = 0; k < n; k++) begin
      int reps;
      reps = (k == 0) ? first_reps : ((k == n - 1) ? last_reps : w);
      for (int r = 0; r < reps; r++) begin
        @(negedge clk);
        if (fc == 0) begin speed_sel = spd; rise = cyc + 1; end
        if (fc == chg_at) speed_sel = chg_spd;
        in_dv = 1'b1; in_data = byte_of(k, seed); in_er = (k == eb && r == eo);
        fc++; len++;
      end
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk); in_dv = 1'b0; in_er = 1'b0;
    end
    @(posedge clk); #2;
    cnt = ev_n - base;
    chk(req, "sample count", cnt, n);
    for (int k = 0; k < n && k < cnt; k++) begin
      if (k < n - 1) expc = rise + k * w + w - 1;
      else expc = (rise + k * w + w - 1 < rise + len) ? rise + k * w + w - 1 : rise + len;
      chk(req, $sformatf("byte %0d data", k), ev_d[base + k], byte_of(k, seed));
      chk("R6", $sformatf("byte %0d err", k), ev_e[base + k], (k == eb) ? 1 : 0);
      chk(req, $sformatf("byte %0d cycle", k), ev_c[base + k], expc);
    end
  endtask

  task automatic t_reset;
    chk("R11", "smp_valid after reset", smp_valid, 0);
    chk("R11", "crs after reset", crs, 0);
    chk("R11", "col after reset", col, 0);
  endtask

  task automatic t_gig;      // R1, R6
    run_frame("R1", 2'b10, 6, 1, 1, 3, 0, 3, -1, 2'b10, 11);
  endtask

  task automatic t_fast;     // R2 with error on the closing slot, R6
    run_frame("R2", 2'b01, 5, 10, 10, 1, 9, 3, -1, 2'b01, 40);
  endtask

  task automatic t_slow;     // R3
    run_frame("R3", 2'b00, 3, 100, 100, 2, 50, 3, -1, 2'b00, 77);
  endtask

  task automatic t_short;    // R5 at both slow rates
    run_frame("R5", 2'b01, 4, 9, 10, 2, 4, 3, -1, 2'b01, 90);
    run_frame("R5", 2'b00, 2, 99, 100, 9, 0, 3, -1, 2'b00, 123);
  endtask

  task automatic t_restart;  // R4 and R7: partial tail, one idle, new frame
    run_frame("R7", 2'b01, 3, 10, 4, 9, 0, 1, -1, 2'b01, 150);
    run_frame("R4", 2'b01, 3, 10, 10, 0, 2, 3, -1, 2'b01, 200);
  endtask

  task automatic t_speed_change;  // R8
    run_frame("R8", 2'b01, 3, 10, 10, 9, 0, 3, 3, 2'b10, 33);
    speed_sel = 2'b10;
  endtask

  task automatic t_reserved;  // R12
    run_frame("R12", 2'b11, 4, 1, 1, 9, 0, 3, -1, 2'b11, 61);
  endtask

  task automatic t_carrier;   // R9, R10
    logic [1:0] pat [4];
    pat[0] = 2'b10; pat[1] = 2'b11; pat[2] = 2'b01; pat[3] = 2'b00;
    speed_sel = 2'b10;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); in_dv = pat[i][1]; tx_en = pat[i][0];
      @(negedge clk);
      chk("R9", $sformatf("crs pattern %0d", i), crs, pat[i][1]);
      chk("R10", $sformatf("col pattern %0d", i), col, pat[i][1] & pat[i][0]);
    end
    @(negedge clk); in_dv = 1'b0; tx_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gig();
    t_fast();
    t_slow();
    t_short();
    t_restart();
    t_speed_change();
    t_reserved();
    t_carrier();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule